// File: doc/BRIEF.md
# Pseudo-static RAM access and refresh sequencer

This block drives a 32K x 8 pseudo-static RAM from a synchronous host port. The memory has three active-low controls: a chip select, a write strobe and a dual-role output enable. With chip select low, the output enable gates read data onto the bus. With chip select high, a low pulse on it makes the memory refresh its next internal row. The sequencer turns one host request into one complete memory cycle. It holds the control pins in the states the memory needs, and it keeps the rows refreshed without any help from the host.

After reset it keeps the memory idle for a long settle period, then issues a fixed number of dummy chip-select cycles before it offers the host port. A free-running interval counter raises a single pending-refresh flag. At the next idle point that flag takes priority over the host, the sequencer emits one refresh pulse, and the host waits. The data bus is modelled as separate input, output and output-enable signals. Every timing value is a parameter in clock cycles; the defaults assume a 100 MHz clock.

Top module: `psram_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, while `mem_dq_oe` and `req_ready` are 0.
- R2: After reset, `mem_cs_n` and `mem_oe_n` stay high for at least PWR_CYC clock cycles.
- R3: After the settle period, exactly DUMMY_N chip-select low pulses with `mem_we_n` high are issued before `req_ready` first goes to 1. `req_ready` stays 0 until then.
- R4: Every chip-select low window lasts max(CE_CYC, WE_CYC, OE_ACC) cycles (10 by default), and `mem_addr` is stable throughout it. Two falling edges of `mem_cs_n` are at least CYC_MIN cycles apart. The address presented equals the accepted `req_addr`.
- R5: A request accepted with `req_write`=1 holds `mem_we_n` low and `mem_dq_oe` high with `req_wdata` on `mem_dq_out` for the whole chip-select window. `mem_we_n` is never low while chip select is high.
- R6: A request accepted with `req_write`=0 drives `mem_oe_n` low for the chip-select window. It samples `mem_dq_in` on the last cycle of that window into `rd_data`, with a one-cycle `rd_valid` pulse on the next cycle.
- R7: A refresh pulse is `mem_oe_n` low with `mem_cs_n` high. It lasts min(RF_LO, RF_LO_MAX) cycles (6 by default), and chip select stays high throughout it. Chip select stays high for at least RF_PRE cycles after the pulse ends.
- R8: After initialisation, the starts of two refresh pulses are never more than REF_WINDOW cycles apart, whether the host is idle or busy.
- R9: A pending refresh is served before a waiting host request. `req_ready` is 0 while a refresh pulse is on the pins.
- R10: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

Ports listed in port order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both 1 |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 15 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Output enable when selected, refresh strobe when deselected, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for mem_dq_out onto the bus |
| mem_dq_in | input | 8 | Data read from the bus |

## Verification
The hardest case to reach from the ports is a host request that arrives while a refresh is already pending or running. Only then does the arbitration order show, and only then does the refresh-gap budget meet its worst case. The bench shortens the settle period and the refresh window through parameters, so refreshes fall among table-driven traffic. It then waits for a refresh pulse on the pins and issues a read at once. It checks that the read waits out the refresh precharge and still returns the stored byte. Back-to-back requests and a long idle stretch cover the chip-select spacing and the gap budget.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_DUM_ACT,
    ST_DUM_PRE,
    ST_IDLE,
    ST_ACC_ACT,
    ST_ACC_PRE,
    ST_RF_LO,
    ST_RF_HI
  } seq_state_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned umin(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_timer.sv
// Down-counter: loading N-1 makes the current state last N cycles.
module psram_seq_timer #(
  parameter int unsigned TW       = 16,
  parameter int unsigned RST_LOAD = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= TW'(RST_LOAD);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/psram_seq_refresh.sv
// Interval counter with a single sticky pending-refresh flag.
module psram_seq_refresh #(
  parameter int unsigned INTERVAL = 1544
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = enable && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= (pending && !ack) || tick;
  end
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned AW         = 15,
  parameter int unsigned DW         = 8,
  parameter int unsigned PWR_CYC    = 20000,
  parameter int unsigned DUMMY_N    = 8,
  parameter int unsigned CE_CYC     = 10,
  parameter int unsigned CE_PRE     = 5,
  parameter int unsigned CYC_MIN    = 16,
  parameter int unsigned WE_CYC     = 6,
  parameter int unsigned OE_ACC     = 4,
  parameter int unsigned RF_LO      = 6,
  parameter int unsigned RF_LO_MAX  = 800,
  parameter int unsigned RF_PRE     = 3,
  parameter int unsigned RF_CYC     = 16,
  parameter int unsigned REF_WINDOW = 1562
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  // derived cycle counts
  localparam int unsigned ACT_CYC  = umax(CE_CYC, umax(WE_CYC, OE_ACC));
  localparam int unsigned PRE_HOLD = umax(umax(CE_PRE, CYC_MIN - ACT_CYC), 2);
  localparam int unsigned PRE_ST   = PRE_HOLD - 1;   // plus one idle cycle
  localparam int unsigned RF_W     = umin(RF_LO, RF_LO_MAX);
  localparam int unsigned RF_HOLD  = umax(umax(RF_PRE, RF_CYC - RF_W), 2);
  localparam int unsigned RF_ST    = RF_HOLD - 1;
  localparam int unsigned MARGIN   = ACT_CYC + PRE_HOLD + 2;
  localparam int unsigned INTERVAL = REF_WINDOW - MARGIN;
  localparam int unsigned TMAX     = umax(PWR_CYC, umax(ACT_CYC, umax(PRE_HOLD, umax(RF_W, RF_HOLD))));
  localparam int unsigned TW       = $clog2(TMAX + 1);
  localparam int unsigned DCW      = $clog2(DUMMY_N + 1);

  seq_state_e     state;
  logic           t_load, t_done;
  logic [TW-1:0]  t_val;
  logic [DCW-1:0] dum_cnt;
  logic           init_done, rf_pend, rf_ack, accept, acc_wr;

  assign req_ready = (state == ST_IDLE) && !rf_pend;
  assign accept    = req_ready && req_valid;
  assign rf_ack    = (state == ST_IDLE) && rf_pend;

  psram_seq_timer #(.TW(TW), .RST_LOAD(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  psram_seq_refresh #(.INTERVAL(INTERVAL)) u_refresh (
    .clk(clk), .rst(rst), .enable(init_done), .ack(rf_ack), .pending(rf_pend)
  );

  // timer reload for the state being entered
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_PWRUP:   if (t_done) begin t_load = 1'b1; t_val = TW'(ACT_CYC - 1); end
      ST_DUM_ACT: if (t_done) begin t_load = 1'b1; t_val = TW'(PRE_HOLD - 1); end
      ST_DUM_PRE: if (t_done && dum_cnt != DCW'(DUMMY_N - 1)) begin
                    t_load = 1'b1; t_val = TW'(ACT_CYC - 1);
                  end
      ST_IDLE:    if (rf_pend) begin t_load = 1'b1; t_val = TW'(RF_W - 1); end
                  else if (accept) begin t_load = 1'b1; t_val = TW'(ACT_CYC - 1); end
      ST_ACC_ACT: if (t_done) begin t_load = 1'b1; t_val = TW'(PRE_ST - 1); end
      ST_RF_LO:   if (t_done) begin t_load = 1'b1; t_val = TW'(RF_ST - 1); end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PWRUP;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      dum_cnt    <= '0;
      init_done  <= 1'b0;
      acc_wr     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_PWRUP: if (t_done) begin
          mem_cs_n <= 1'b0;
          state    <= ST_DUM_ACT;
        end
        ST_DUM_ACT: if (t_done) begin
          mem_cs_n <= 1'b1;
          state    <= ST_DUM_PRE;
        end
        ST_DUM_PRE: if (t_done) begin
          if (dum_cnt == DCW'(DUMMY_N - 1)) begin
            init_done <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            dum_cnt  <= dum_cnt + 1'b1;
            mem_cs_n <= 1'b0;
            state    <= ST_DUM_ACT;
          end
        end
        ST_IDLE: begin
          if (rf_pend) begin
            mem_oe_n <= 1'b0;
            state    <= ST_RF_LO;
          end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            acc_wr     <= req_write;
            mem_cs_n   <= 1'b0;
            mem_we_n   <= !req_write;
            mem_oe_n   <= req_write;
            mem_dq_oe  <= req_write;
            state      <= ST_ACC_ACT;
          end
        end
        ST_ACC_ACT: if (t_done) begin
          mem_cs_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          if (!acc_wr) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
          end
          state <= ST_ACC_PRE;
        end
        ST_ACC_PRE: if (t_done) state <= ST_IDLE;
        ST_RF_LO: if (t_done) begin
          mem_oe_n <= 1'b1;
          state    <= ST_RF_HI;
        end
        ST_RF_HI: if (t_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_seq_chk.sv
module psram_seq_chk #(
  parameter int unsigned AW         = 15,
  parameter int unsigned PWR_CYC    = 20000,
  parameter int unsigned CE_CYC     = 10,
  parameter int unsigned RF_LO      = 6,
  parameter int unsigned RF_LO_MAX  = 800,
  parameter int unsigned REF_WINDOW = 1562
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          init_done
);
  logic [31:0] cyc_cnt, cs_lo_cnt, rf_lo_cnt, gap_cnt;
  logic        rf_on;

  assign rf_on = !oe_n && cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt   <= '0;
      cs_lo_cnt <= '0;
      rf_lo_cnt <= '0;
      gap_cnt   <= '0;
    end else begin
      if (cyc_cnt < PWR_CYC) cyc_cnt <= cyc_cnt + 1;
      cs_lo_cnt <= cs_n  ? '0 : cs_lo_cnt + 1;
      rf_lo_cnt <= rf_on ? rf_lo_cnt + 1 : '0;
      gap_cnt   <= (!init_done || rf_on) ? '0 : gap_cnt + 1;
    end
  end

  // R2
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_cnt < PWR_CYC) |-> (cs_n && oe_n));
  // R3
  init_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !req_ready);
  // R4
  cs_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (cs_lo_cnt >= CE_CYC));
  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
  // R5
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cs_n && dq_oe));
  // R6
  rd_source_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!cs_n && !oe_n));
  // R7
  rf_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_n) && $past(cs_n)) |-> (rf_lo_cnt >= RF_LO && rf_lo_cnt <= RF_LO_MAX));
  // R7
  rf_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && $past(!oe_n) && $past(cs_n)) |-> cs_n);
  // R8
  rf_gap_chk: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= REF_WINDOW);
  // R9
  rf_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rf_on |-> !req_ready);
  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !oe_n));
endmodule

bind psram_seq psram_seq_chk #(
  .AW(AW), .PWR_CYC(PWR_CYC), .CE_CYC(CE_CYC), .RF_LO(RF_LO),
  .RF_LO_MAX(RF_LO_MAX), .REF_WINDOW(REF_WINDOW)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
  .dq_oe(mem_dq_oe), .addr(mem_addr), .req_ready(req_ready),
  .rd_valid(rd_valid), .init_done(init_done)
);

// File: tb/psram_seq_tb.sv
`timescale 1ns/1ps
module psram_seq_tb;
  localparam int PWR   = 300;
  localparam int WIN   = 200;
  localparam int CEW   = 10;
  localparam int CYC   = 16;
  localparam int RFW   = 6;
  localparam int RFPRE = 3;
  localparam int NDUM  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;

  always #4 clk = ~clk;

  psram_seq #(.PWR_CYC(PWR), .REF_WINDOW(WIN)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model, indexed by the low address byte
  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_out;
  always_comb mem_dq_in = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 8'h00;

  // pin monitor
  int cyc, cs_run, cs_bad, cs_falls, first_cs, last_cs_fall, min_sp;
  int rf_run, rf_bad, rf_pulses, last_rf, max_gap, rf_end, cs_before_rdy;
  int we_init, overlap, rdy_in_rf;
  bit rdy_seen, prev_cs, prev_rf;
  logic [14:0] fall_addr;

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; cs_run = 0; cs_bad = 0; cs_falls = 0; first_cs = -1; last_cs_fall = -1;
      min_sp = 1 << 30; rf_run = 0; rf_bad = 0; rf_pulses = 0; last_rf = -1; max_gap = 0;
      rf_end = -1; cs_before_rdy = 0; we_init = 0; overlap = 0; rdy_in_rf = 0;
      rdy_seen = 0; prev_cs = 1; prev_rf = 0; fall_addr = '0;
    end else begin
      bit rf;
      cyc++;
      rf = !mem_oe_n && mem_cs_n;
      if (!mem_cs_n) cs_run++;
      else if (cs_run != 0) begin if (cs_run != CEW) cs_bad++; cs_run = 0; end
      if (!mem_cs_n && prev_cs) begin
        cs_falls++;
        if (first_cs < 0) first_cs = cyc;
        if (last_cs_fall >= 0 && cyc - last_cs_fall < min_sp) min_sp = cyc - last_cs_fall;
        last_cs_fall = cyc;
        fall_addr = mem_addr;
        if (!rdy_seen) cs_before_rdy++;
      end
      if (req_ready) rdy_seen = 1;
      if (!rdy_seen && !mem_we_n) we_init++;
      if (rf) rf_run++;
      else if (rf_run != 0) begin if (rf_run != RFW) rf_bad++; rf_run = 0; rf_end = cyc; end
      if (rf && !prev_rf) begin
        rf_pulses++;
        if (last_rf >= 0 && cyc - last_rf > max_gap) max_gap = cyc - last_rf;
        last_rf = cyc;
      end
      if (mem_dq_oe && !mem_oe_n) overlap++;
      if (rf && req_ready) rdy_in_rf++;
      prev_cs = mem_cs_n;
      prev_rf = rf;
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic txn(bit wr, logic [14:0] a, logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(fall_addr == a, "R4 address", int'(fall_addr), int'(a));
    rd = 8'h00;
    if (!wr) begin
      while (!rd_valid) @(negedge clk);
      rd = rd_data;
    end
  endtask

  // {write, addr[14:0], data[7:0]}; for reads the data field is the expected byte
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 15'h0000, 8'h3C}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'hC3},
    {1'b0, 15'h0000, 8'h3C}, {1'b0, 15'h7FFF, 8'h5A}, {1'b0, 15'h1234, 8'hC3},
    {1'b1, 15'h1234, 8'h00}, {1'b0, 15'h1234, 8'h00},
    {1'b1, 15'h00AA, 8'hFF}, {1'b0, 15'h00AA, 8'hFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R1 reset pins",
        int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}), 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && !req_ready, "R1 first cycle", int'({mem_cs_n, mem_oe_n, req_ready}), 3'b110);
    while (!req_ready) @(negedge clk);
    // R2 settle period, R3 dummy cycles
    chk(first_cs > PWR, "R2 settle length", first_cs, PWR + 1);
    chk(cs_before_rdy == NDUM, "R3 dummy count", cs_before_rdy, NDUM);
    chk(we_init == 0, "R3 dummy writes", we_init, 0);

    // R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][23], VEC[i][22:8], VEC[i][7:0], rd);
      if (!VEC[i][23]) chk(rd == VEC[i][7:0], "R6 read data", int'(rd), int'(VEC[i][7:0]));
    end

    // R4 back-to-back reads
    for (int i = 0; i < 6; i++) begin
      txn(1'b0, 15'h7FFF, 8'h00, rd);
      chk(rd == 8'h5A, "R6 repeated read", int'(rd), 8'h5A);
    end
    chk(cs_bad == 0, "R4 cs window", cs_bad, 0);
    chk(min_sp >= CYC, "R4 cs spacing", min_sp, CYC);

    // R9 request issued while a refresh pulse is on the pins
    while (!(!mem_oe_n && mem_cs_n)) @(negedge clk);
    txn(1'b0, 15'h0000, 8'h00, rd);
    chk(rd == 8'h3C, "R9 read after refresh", int'(rd), 8'h3C);
    chk(last_cs_fall - rf_end >= RFPRE, "R7 precharge after refresh", last_cs_fall - rf_end, RFPRE);

    // R8 idle stretch
    p0 = rf_pulses;
    repeat (700) @(negedge clk);
    chk(rf_pulses - p0 >= 3, "R8 idle refresh", rf_pulses - p0, 3);
    chk(max_gap <= WIN, "R8 refresh gap", max_gap, WIN);
    chk(rf_pulses > 0 && rf_bad == 0, "R7 pulse width", rf_bad, 0);
    chk(rdy_in_rf == 0, "R9 ready during refresh", rdy_in_rf, 0);
    chk(overlap == 0, "R10 bus overlap", overlap, 0);

    summary();
    $finish;
  end
endmodule